// File: doc/BRIEF.md
# ALU Status Flag Generator

This block sits beside an integer ALU. From the two operands, the ALU result and the ALU's carry-out or borrow-out, it derives the six arithmetic status flags: carry, parity, auxiliary carry, zero, sign and overflow. It keeps them in a flags register. An operation class tells it whether the operation was an addition, a subtraction, a logic operation, a data transfer or a control operation. An operand size select picks 8-, 16- or 32-bit interpretation of the values.

Two further control flags live in the same register: the string direction flag and the interrupt-enable flag. Each has its own set and clear strobes, and these act independently of the arithmetic update path. Every flag output comes straight from a register. A write on one clock edge is visible at the outputs right after that edge.

Top module: `alu_flag_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all eight flag outputs to 0.
- R2: On an add (op_class 0) or subtract (op_class 1) with flag_we_i high, carry_o takes carry_i (carry-out of the addition, borrow of the subtraction).
- R3: On an add, subtract or logic update, parity_o is 1 when result_i[7:0] holds an even number of ones and 0 when odd, for every operand size.
- R4: On an add or subtract update, aux_o is the carry (add) or borrow (subtract) between bit 3 and bit 4, derived from opnd_a_i[4], opnd_b_i[4] and result_i[4].
- R5: On an add, subtract or logic update, zero_o is 1 exactly when the result at the selected size is zero.
- R6: On an add, subtract or logic update, sign_o takes the most significant bit of the result at the selected size.
- R7: On an add or subtract update, ovf_o is 1 exactly when the signed result at the selected size lies outside the representable range.
- R8: On a logic update (op_class 2), carry_o and ovf_o become 0 and aux_o keeps its value.
- R9: Data transfer (op_class 3), control (op_class 4), op_class codes 5 to 7, or flag_we_i low leave all six arithmetic flags unchanged.
- R10: dir_set_i high sets dir_o at the next edge; dir_clr_i alone clears it; set wins when both are high; with neither, dir_o holds.
- R11: ien_set_i and ien_clr_i control ien_o in the same way as R10, with set winning.
- R12: op_size_i 0 selects 8 bits, 1 selects 16 bits, 2 and 3 select 32 bits; bits above the selected size are ignored by the zero, sign and overflow flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a_i | input | 32 | First ALU operand (minuend for subtract) |
| opnd_b_i | input | 32 | Second ALU operand (subtrahend for subtract) |
| result_i | input | 32 | ALU result |
| carry_i | input | 1 | ALU carry-out (add) or borrow-out (subtract) at the selected size |
| op_class_i | input | 3 | 0 add, 1 subtract, 2 logic, 3 data transfer, 4 control |
| op_size_i | input | 2 | 0 byte, 1 word, 2/3 doubleword |
| flag_we_i | input | 1 | Arithmetic flag update enable |
| dir_set_i | input | 1 | Set direction flag |
| dir_clr_i | input | 1 | Clear direction flag |
| ien_set_i | input | 1 | Set interrupt-enable flag |
| ien_clr_i | input | 1 | Clear interrupt-enable flag |
| carry_o | output | 1 | Carry flag |
| parity_o | output | 1 | Parity flag (1 = even) |
| aux_o | output | 1 | Auxiliary carry flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| ovf_o | output | 1 | Overflow flag |
| dir_o | output | 1 | Direction flag |
| ien_o | output | 1 | Interrupt-enable flag |

## Verification
Every flag has one register between its inputs and its output. An update or strobe applied before a rising edge therefore shows at the outputs after that edge and no later. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It compares all eight outputs at that second falling edge, so each check lands exactly one cycle after its stimulus. Before comparing, the bench returns the inputs to idle. Any hold requirement is then observed on the same sample, before another update can reach the register.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int unsigned FLAG_DATA_W = 32;
    localparam int unsigned FLAG_NUM_SIZES = 3;

    typedef enum logic [2:0] {
        OPC_ADD   = 3'd0,
        OPC_SUB   = 3'd1,
        OPC_LOGIC = 3'd2,
        OPC_MOVE  = 3'd3,
        OPC_CTRL  = 3'd4
    } op_class_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
        logic df;
        logic ie;
    } flag_vec_t;

endpackage

// File: rtl/flag_width_view.sv
module flag_width_view #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_SIZES = 3
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic [1:0]        size_sel,
    output logic              a_msb,
    output logic              b_msb,
    output logic              r_msb,
    output logic              r_zero,
    output logic              r_even
);
    localparam int unsigned IDX_W = $clog2(NUM_SIZES + 1);

    logic [NUM_SIZES-1:0] lane_zero;
    logic [IDX_W-1:0]     lane_idx;
    logic [5:0]           msb_pos;

    // one zero detector per supported operand width
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int unsigned LW = 8 << g;
        assign lane_zero[g] = ~|result[LW-1:0];
    end

    always_comb begin
        if (32'(size_sel) >= NUM_SIZES - 1) begin
            lane_idx = IDX_W'(NUM_SIZES - 1);
        end else begin
            lane_idx = IDX_W'(size_sel);
        end
        msb_pos = 6'((8 << lane_idx) - 1);
    end

    assign a_msb  = opnd_a[msb_pos];
    assign b_msb  = opnd_b[msb_pos];
    assign r_msb  = result[msb_pos];
    assign r_zero = lane_zero[lane_idx];
    assign r_even = ~^result[7:0];

endmodule

// File: rtl/flag_arith_core.sv
module flag_arith_core (
    input  logic is_sub,
    input  logic a_nib,
    input  logic b_nib,
    input  logic r_nib,
    input  logic a_msb,
    input  logic b_msb,
    input  logic r_msb,
    output logic aux_carry,
    output logic signed_ovf
);
    logic b_eff;

    // bit 4 of a+b or a-b differs from a^b exactly by the carry/borrow into it
    assign aux_carry = a_nib ^ b_nib ^ r_nib;

    // a subtract behaves like adding an operand of opposite sign
    assign b_eff      = b_msb ^ is_sub;
    assign signed_ovf = (a_msb == b_eff) && (r_msb != a_msb);

endmodule

// File: rtl/flag_ctl_bit.sv
module flag_ctl_bit (
    input  logic cur,
    input  logic set_s,
    input  logic clr_s,
    output logic nxt
);
    always_comb begin
        if (set_s) begin
            nxt = 1'b1;
        end else if (clr_s) begin
            nxt = 1'b0;
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int unsigned DATA_W = FLAG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] opnd_a_i,
    input  logic [DATA_W-1:0] opnd_b_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              carry_i,
    input  logic [2:0]        op_class_i,
    input  logic [1:0]        op_size_i,
    input  logic              flag_we_i,
    input  logic              dir_set_i,
    input  logic              dir_clr_i,
    input  logic              ien_set_i,
    input  logic              ien_clr_i,
    output logic              carry_o,
    output logic              parity_o,
    output logic              aux_o,
    output logic              zero_o,
    output logic              sign_o,
    output logic              ovf_o,
    output logic              dir_o,
    output logic              ien_o
);
    flag_vec_t flags_d, flags_q;

    logic a_msb, b_msb, r_msb, r_zero, r_even;
    logic aux_c, s_ovf;
    logic df_d, ie_d;

    flag_width_view #(
        .DATA_W   (DATA_W),
        .NUM_SIZES(FLAG_NUM_SIZES)
    ) u_view (
        .opnd_a  (opnd_a_i),
        .opnd_b  (opnd_b_i),
        .result  (result_i),
        .size_sel(op_size_i),
        .a_msb   (a_msb),
        .b_msb   (b_msb),
        .r_msb   (r_msb),
        .r_zero  (r_zero),
        .r_even  (r_even)
    );

    flag_arith_core u_arith (
        .is_sub    (op_class_i == OPC_SUB),
        .a_nib     (opnd_a_i[4]),
        .b_nib     (opnd_b_i[4]),
        .r_nib     (result_i[4]),
        .a_msb     (a_msb),
        .b_msb     (b_msb),
        .r_msb     (r_msb),
        .aux_carry (aux_c),
        .signed_ovf(s_ovf)
    );

    flag_ctl_bit u_dir (
        .cur  (flags_q.df),
        .set_s(dir_set_i),
        .clr_s(dir_clr_i),
        .nxt  (df_d)
    );

    flag_ctl_bit u_ien (
        .cur  (flags_q.ie),
        .set_s(ien_set_i),
        .clr_s(ien_clr_i),
        .nxt  (ie_d)
    );

    always_comb begin
        flags_d    = flags_q;
        flags_d.df = df_d;
        flags_d.ie = ie_d;
        if (flag_we_i) begin
            case (op_class_i)
                OPC_ADD, OPC_SUB: begin
                    flags_d.cf = carry_i;
                    flags_d.pf = r_even;
                    flags_d.af = aux_c;
                    flags_d.zf = r_zero;
                    flags_d.sf = r_msb;
                    flags_d.of = s_ovf;
                end
                OPC_LOGIC: begin
                    flags_d.cf = 1'b0;
                    flags_d.pf = r_even;
                    flags_d.zf = r_zero;
                    flags_d.sf = r_msb;
                    flags_d.of = 1'b0;
                end
                default: begin
                    flags_d.cf = flags_q.cf;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign carry_o  = flags_q.cf;
    assign parity_o = flags_q.pf;
    assign aux_o    = flags_q.af;
    assign zero_o   = flags_q.zf;
    assign sign_o   = flags_q.sf;
    assign ovf_o    = flags_q.of;
    assign dir_o    = flags_q.df;
    assign ien_o    = flags_q.ie;

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] result_i,
    input logic [2:0]        op_class_i,
    input logic [1:0]        op_size_i,
    input logic              flag_we_i,
    input logic              dir_set_i,
    input logic              dir_clr_i,
    input logic              ien_set_i,
    input logic              ien_clr_i,
    input logic              carry_o,
    input logic              parity_o,
    input logic              aux_o,
    input logic              zero_o,
    input logic              sign_o,
    input logic              ovf_o,
    input logic              dir_o,
    input logic              ien_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> {carry_o, parity_o, aux_o, zero_o, sign_o, ovf_o, dir_o, ien_o} == 8'h00);

    // R9
    no_touch_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_we_i || op_class_i > 3'd2)
        |=> $stable({carry_o, parity_o, aux_o, zero_o, sign_o, ovf_o}));

    // R8
    logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_class_i == 3'd2) |=> (!carry_o && !ovf_o && $stable(aux_o)));

    // R5
    byte_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_class_i <= 3'd2 && op_size_i == 2'd0 && result_i[7:0] == 8'h00)
        |=> zero_o);

    // R10
    dir_set_chk: assert property (@(posedge clk) disable iff (rst)
        dir_set_i |=> dir_o);

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!dir_set_i && !dir_clr_i) |=> $stable(dir_o));

    // R11
    ien_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ien_clr_i && !ien_set_i) |=> !ien_o);

    // R11
    ien_set_chk: assert property (@(posedge clk) disable iff (rst)
        ien_set_i |=> ien_o);

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .result_i  (result_i),
    .op_class_i(op_class_i),
    .op_size_i (op_size_i),
    .flag_we_i (flag_we_i),
    .dir_set_i (dir_set_i),
    .dir_clr_i (dir_clr_i),
    .ien_set_i (ien_set_i),
    .ien_clr_i (ien_clr_i),
    .carry_o   (carry_o),
    .parity_o  (parity_o),
    .aux_o     (aux_o),
    .zero_o    (zero_o),
    .sign_o    (sign_o),
    .ovf_o     (ovf_o),
    .dir_o     (dir_o),
    .ien_o     (ien_o)
);

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_a = '0, opnd_b = '0, result = '0;
    logic        carry = 1'b0;
    logic [2:0]  op_class = 3'd3;
    logic [1:0]  op_size = 2'd0;
    logic        we = 1'b0, ds = 1'b0, dc = 1'b0, is_ = 1'b0, ic = 1'b0;
    logic        cf, pf, af, zf, sf, of, df, ie;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference flag state
    logic m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0, m_df = 0, m_ie = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flag_unit u_alu_flag_unit (
        .clk(clk), .rst(rst), .opnd_a_i(opnd_a), .opnd_b_i(opnd_b), .result_i(result),
        .carry_i(carry), .op_class_i(op_class), .op_size_i(op_size), .flag_we_i(we),
        .dir_set_i(ds), .dir_clr_i(dc), .ien_set_i(is_), .ien_clr_i(ic),
        .carry_o(cf), .parity_o(pf), .aux_o(af), .zero_o(zf), .sign_o(sf), .ovf_o(of),
        .dir_o(df), .ien_o(ie)
    );

    task automatic check_bit(string tag, string ctx, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, ctx, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        check_bit("R2", ctx, cf, m_cf);
        check_bit("R3", ctx, pf, m_pf);
        check_bit("R4", ctx, af, m_af);
        check_bit("R5", ctx, zf, m_zf);
        check_bit("R6", ctx, sf, m_sf);
        check_bit("R7", ctx, of, m_of);
        check_bit("R10", ctx, df, m_df);
        check_bit("R11", ctx, ie, m_ie);
    endtask

    task automatic go_idle();
        we = 0; ds = 0; dc = 0; is_ = 0; ic = 0; op_class = 3'd3;
    endtask

    function automatic logic [31:0] size_mask(int w);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    endfunction

    function automatic longint as_signed(logic [31:0] v, int w);
        longint x = longint'(v);
        if (v[w-1]) x = x - (longint'(1) << w);
        return x;
    endfunction

    // add or subtract at size sz; junk fills the bits above the selected size (R12)
    task automatic arith_op(bit sub, int sz, logic [31:0] a, logic [31:0] b,
                            logic [31:0] junk, string ctx);
        int          w = 8 << ((sz >= 2) ? 2 : sz);
        logic [31:0] mk = size_mask(w);
        logic [31:0] av = a & mk, bv = b & mk, rv;
        logic [63:0] s64;
        longint      sr;
        if (sub) begin
            rv    = (av - bv) & mk;
            carry = av < bv;
            sr    = as_signed(av, w) - as_signed(bv, w);
            m_af  = (av & 32'hF) < (bv & 32'hF);
        end else begin
            s64   = {32'b0, av} + {32'b0, bv};
            rv    = s64[31:0] & mk;
            carry = s64[w];
            sr    = as_signed(av, w) + as_signed(bv, w);
            m_af  = ((av & 32'hF) + (bv & 32'hF)) > 32'hF;
        end
        m_cf = carry;
        m_of = (sr > ((longint'(1) << (w-1)) - 1)) || (sr < -(longint'(1) << (w-1)));
        m_zf = (rv == 0);
        m_sf = rv[w-1];
        m_pf = ($countones(rv[7:0]) % 2) == 0;
        opnd_a = av | (junk & ~mk);
        opnd_b = bv | (~junk & ~mk);
        result = rv | (junk & ~mk);
        op_size = 2'(sz);
        op_class = sub ? 3'd1 : 3'd0;
        we = 1;
        @(negedge clk);
        go_idle();
        check_all(ctx);
    endtask

    // R8: logic update
    task automatic logic_op(int sz, logic [31:0] rv_in, string ctx);
        int          w = 8 << ((sz >= 2) ? 2 : sz);
        logic [31:0] mk = size_mask(w);
        m_cf = 0; m_of = 0;
        m_zf = ((rv_in & mk) == 0);
        m_sf = rv_in[w-1];
        m_pf = ($countones(rv_in[7:0]) % 2) == 0;
        result = rv_in; opnd_a = ~rv_in; opnd_b = rv_in ^ 32'h0000_0010;
        carry = 1; op_size = 2'(sz); op_class = 3'd2; we = 1;
        @(negedge clk);
        go_idle();
        check_bit("R8", ctx, cf, 1'b0);
        check_bit("R8", ctx, of, 1'b0);
        check_bit("R8", ctx, af, m_af);
        check_all(ctx);
    endtask

    // R9: operation that must not touch arithmetic flags
    task automatic quiet_op(logic [2:0] opc, logic w_en, string ctx);
        result = 32'h0; opnd_a = 32'h7F; opnd_b = 32'h01; carry = ~m_cf;
        op_size = 2'd0; op_class = opc; we = w_en;
        @(negedge clk);
        go_idle();
        check_bit("R9", ctx, {cf, pf, af, zf, sf, of} == {m_cf, m_pf, m_af, m_zf, m_sf, m_of}, 1'b1);
        check_all(ctx);
    endtask

    task automatic strobe(logic s_d, logic c_d, logic s_i, logic c_i, string ctx);
        ds = s_d; dc = c_d; is_ = s_i; ic = c_i;
        if (s_d) m_df = 1; else if (c_d) m_df = 0;
        if (s_i) m_ie = 1; else if (c_i) m_ie = 0;
        @(negedge clk);
        go_idle();
        check_all(ctx);
    endtask

    function automatic logic [31:0] pattern(int k, int w);
        logic [31:0] mk = size_mask(w);
        case (k)
            0: return 32'h0;
            1: return 32'h1;
            2: return mk;
            3: return (32'h1 << (w-1));
            4: return (32'h1 << (w-1)) - 1;
            5: return 32'h0F;
            6: return 32'h5A5A_5A5A & mk;
            default: return 32'hC3A5_1F70 & mk;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("R1", "after reset", {cf, pf, af, zf, sf, of, df, ie} == 8'h00, 1'b1);
        rst = 0;
        @(negedge clk);

        // R10, R11: strobes including simultaneous set/clear
        strobe(1, 0, 0, 0, "R10 dir set");
        strobe(0, 0, 1, 1, "R11 ien both");
        strobe(0, 1, 0, 0, "R10 dir clr");
        strobe(1, 1, 0, 1, "R10 both R11 clr");
        strobe(0, 0, 0, 0, "R10 R11 hold");

        // byte-size sweep with junk upper bits (R12)
        for (int a = 0; a < 256; a++) begin
            for (int j = 0; j < 32; j++) begin
                logic [31:0] b = 32'((j % 16) * 17) ^ ((j >= 16) ? 32'h08 : 32'h0);
                arith_op(0, 0, 32'(a), b, 32'hA5C3_96F0, "R12 byte add");
                arith_op(1, 0, 32'(a), b, 32'h3C5A_0F00, "R12 byte sub");
            end
        end

        // word and doubleword patterns
        for (int sz = 1; sz < 4; sz++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    int w = 8 << ((sz >= 2) ? 2 : sz);
                    arith_op(0, sz, pattern(i, w), pattern(j, w), 32'hDEAD_BEEF, "R12 wide add");
                    arith_op(1, sz, pattern(i, w), pattern(j, w), 32'hFFFF_FFFF, "R12 wide sub");
                end
            end
        end

        // R8: logic ops after an op that set aux carry
        arith_op(0, 0, 32'h0F, 32'h01, 32'h0, "R4 setup");
        logic_op(0, 32'hFFFF_FF00, "R8 byte zero");
        logic_op(1, 32'h0000_8001, "R8 word sign");
        logic_op(2, 32'h8000_0000, "R8 dword sign");
        arith_op(1, 2, 32'h0, 32'h1, 32'h0, "R7 setup");
        logic_op(0, 32'h0000_0003, "R8 clears after sub");

        // R9: non-updating operations
        arith_op(1, 0, 32'h80, 32'h01, 32'h0, "R9 setup");
        quiet_op(3'd3, 1, "R9 move");
        quiet_op(3'd4, 1, "R9 ctrl");
        quiet_op(3'd6, 1, "R9 unused code");
        quiet_op(3'd0, 0, "R9 we low");

        // R1: reset while flags are set
        strobe(1, 0, 1, 0, "R1 setup");
        rst = 1;
        @(negedge clk);
        rst = 0;
        m_cf = 0; m_pf = 0; m_af = 0; m_zf = 0; m_sf = 0; m_of = 0; m_df = 0; m_ie = 0;
        check_bit("R1", "reset mid-run", {cf, pf, af, zf, sf, of, df, ie} == 8'h00, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule